// File: doc/BRIEF.md
# SMBus Voltage-ID Register Slave

This block is a small SMBus target that holds two 5-bit voltage-identification (VID) codes and a one-bit power-enable flag. A host loads both codes in a single Write Word transaction and reads them back with Read Word. A select input picks which of the two codes drives the 5-bit VID output bus. Software can therefore switch the supply between two preloaded operating points with a single pin and no bus traffic.

The bus lines arrive already synchronized to the system clock. The block oversamples them and detects SCL edges, START and STOP itself. The open-drain data line is modelled by an output enable: when it is high, the pin is pulled low. Written data is staged while the transfer is in progress. The registers change only when a complete, acknowledged word is closed by a STOP or a repeated START. Any change in value raises a one-cycle update pulse.

Top module: `smbus_vid_slave`

## Requirements
- R1: The slave answers only to 7-bit address 1110001. The R/W bit is bit 0 of the address byte: 0 means a write, 1 means a read. For a matching address the slave pulls SDA low during the ninth clock. For any other address it leaves SDA released and ignores the rest of the transfer.
- R2: After reset both VID registers hold 11111, the power flag is 0, the update pulse is 0 and SDA is released.
- R3: Only command bits 7..5 are decoded, and bits 4..0 have no effect. Codes 000 to 011 are acknowledged. Any code with bit 7 set is not acknowledged, and the whole transfer then changes nothing.
- R4: A Write Word with command code 001 loads data-low bits 7..3 into VID register 0 and data-high bits 7..3 into VID register 1. The new values appear on the clock edge that samples the closing STOP or repeated START.
- R5: The update pulse is high for exactly one cycle, on the cycle the registers take new values, and only if at least one VID register changes. Rewriting the same values gives no pulse.
- R6: A write that ends before both data bytes have been acknowledged leaves every register unchanged.
- R7: A Read Word after command 001 returns register 0 then register 1. Each byte is the 5-bit code in bits 7..3 with zeros in bits 2..0, sent most significant bit first. The host acknowledges the first byte and not the second.
- R8: The VID output bus shows register 0 when the select input is 0 and register 1 when it is 1.
- R9: Command code 010 accesses the power flag. A Write Word copies data-low bit 7 into the flag. A Read Word returns the flag in bit 7 of the low byte and zeros elsewhere in both bytes. Codes 000 and 011 are acknowledged but change no register.
- R10: The SDA drive enable changes only on the clock after a sampled SCL falling edge, or at START or STOP. It is released at STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Synchronized SMBus clock line |
| sda_i | input | 1 | Synchronized SMBus data line (wired level) |
| vid_sel_i | input | 1 | Selects register 0 (0) or register 1 (1) onto the VID bus |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| vid_o | output | 5 | Selected VID code |
| vid_reg0_o | output | 5 | VID register 0 |
| vid_reg1_o | output | 5 | VID register 1 |
| pwr_on_o | output | 1 | Power-enable flag |
| upd_pulse_o | output | 1 | One-cycle pulse when a VID register changes value |

## Verification
The SDA drive enable is due one clock after the slave samples an SCL falling edge. Register, flag and update-pulse changes are due on the edge that samples SDA rising (STOP) or falling (repeated START) while SCL is high. The select mux is combinational. The bench moves the bus lines on falling clock edges and holds each bus phase for four clocks. It samples ACK bits and read data in the middle of the SCL high phase, and checks registers only after the STOP phase has finished. Update pulses are counted on every clock, so a missing, extra or stretched pulse shows up as a wrong count after each transaction.

// File: rtl/vid_pkg.sv
// Package: shared types and constants of the SMBus VID slave.
// Assumes one byte is eight bits and the command field is the top three bits.
package vid_pkg;
    localparam int BYTE_W = 8;
    localparam int CMD_W  = 3;

    localparam logic [CMD_W-1:0] CMD_VID = 3'b001;
    localparam logic [CMD_W-1:0] CMD_PWR = 3'b010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_WLO,
        ST_WHI,
        ST_RLO,
        ST_RHI,
        ST_WAIT
    } smb_state_t;
endpackage

// File: rtl/smb_line_mon.sv
// Module: watches the synchronized SCL/SDA lines and flags SCL edges,
// START and STOP as single-cycle strobes.
// Assumes both inputs are already synchronized to clk and idle high.
module smb_line_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_q;
    logic sda_q;

    // Keep the previous line levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // Decode edges and bus conditions from old and new levels.
    always_comb begin
        scl_rise_o = scl_i & ~scl_q;
        scl_fall_o = ~scl_i & scl_q;
        start_o    = scl_i & scl_q & sda_q & ~sda_i;
        stop_o     = scl_i & scl_q & ~sda_q & sda_i;
    end
endmodule

// File: rtl/smb_word_fsm.sv
// Module: SMBus word-protocol engine. Matches the address, decodes the
// command, collects two data bytes, drives ACK and read data, and raises
// a commit strobe when a fully acknowledged word is closed by STOP or
// repeated START.
// Assumes the line monitor strobes and a register bank supplying read data.
module smb_word_fsm #(
    parameter logic [6:0] SLAVE_ADDR = 7'b1110001,
    parameter int         VID_W      = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_i,
    input  logic             scl_rise_i,
    input  logic             scl_fall_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [VID_W-1:0] rd_vid0_i,
    input  logic [VID_W-1:0] rd_vid1_i,
    input  logic             rd_flag_i,
    output logic             sda_oe_o,
    output logic             commit_o,
    output logic [vid_pkg::CMD_W-1:0] cmd_o,
    output logic [VID_W-1:0] lo_o,
    output logic [VID_W-1:0] hi_o
);
    import vid_pkg::*;

    localparam int                CNT_W    = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0]  ACK_SLOT = CNT_W'(BYTE_W);
    localparam int                PAD_W    = BYTE_W - VID_W;

    smb_state_t         state;
    logic [CNT_W-1:0]   bit_cnt;
    logic [BYTE_W-1:0]  shreg;
    logic               word_ok;
    logic [BYTE_W-1:0]  tx_lo;
    logic [BYTE_W-1:0]  tx_hi;
    logic [BYTE_W-1:0]  tx_sh;
    logic               drive_nxt;

    // Build the read bytes from the command of the current transfer.
    always_comb begin
        tx_lo = '0;
        tx_hi = '0;
        if (cmd_o == CMD_VID) begin
            tx_lo = {rd_vid0_i, {PAD_W{1'b0}}};
            tx_hi = {rd_vid1_i, {PAD_W{1'b0}}};
        end else if (cmd_o == CMD_PWR) begin
            tx_lo = {rd_flag_i, {(BYTE_W-1){1'b0}}};
        end
        tx_sh = ((state == ST_RHI) ? tx_hi : tx_lo) << bit_cnt;
    end

    // Decide what SDA should do after the next SCL falling edge.
    always_comb begin
        unique case (state)
            ST_ADDR: drive_nxt = (bit_cnt == ACK_SLOT) && (shreg[BYTE_W-1:1] == SLAVE_ADDR);
            ST_CMD:  drive_nxt = (bit_cnt == ACK_SLOT) && !shreg[BYTE_W-1];
            ST_WLO,
            ST_WHI:  drive_nxt = (bit_cnt == ACK_SLOT);
            ST_RLO,
            ST_RHI:  drive_nxt = (bit_cnt != ACK_SLOT) && !tx_sh[BYTE_W-1];
            default: drive_nxt = 1'b0;
        endcase
    end

    // A staged word is committed at the bus condition that closes it.
    assign commit_o = word_ok & (start_i | stop_i);

    // Protocol sequencing: bit shifting, byte decisions and SDA drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            word_ok  <= 1'b0;
            sda_oe_o <= 1'b0;
            cmd_o    <= CMD_VID;
            lo_o     <= '0;
            hi_o     <= '0;
        end else if (start_i) begin
            state    <= ST_ADDR;
            bit_cnt  <= '0;
            word_ok  <= 1'b0;
            sda_oe_o <= 1'b0;
        end else if (stop_i) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            word_ok  <= 1'b0;
            sda_oe_o <= 1'b0;
        end else if (scl_rise_i) begin
            if (state == ST_IDLE || state == ST_WAIT) begin
                bit_cnt <= '0;
            end else if (bit_cnt != ACK_SLOT) begin
                shreg   <= {shreg[BYTE_W-2:0], sda_i};
                bit_cnt <= bit_cnt + 1'b1;
            end else begin
                bit_cnt <= '0;
                unique case (state)
                    ST_ADDR: begin
                        if (shreg[BYTE_W-1:1] != SLAVE_ADDR) state <= ST_WAIT;
                        else if (shreg[0])                  state <= ST_RLO;
                        else                                state <= ST_CMD;
                    end
                    ST_CMD: begin
                        if (!shreg[BYTE_W-1]) begin
                            cmd_o <= shreg[BYTE_W-1 -: CMD_W];
                            state <= ST_WLO;
                        end else begin
                            state <= ST_WAIT;
                        end
                    end
                    ST_WLO: begin
                        lo_o  <= shreg[BYTE_W-1 -: VID_W];
                        state <= ST_WHI;
                    end
                    ST_WHI: begin
                        hi_o    <= shreg[BYTE_W-1 -: VID_W];
                        word_ok <= 1'b1;
                        state   <= ST_WAIT;
                    end
                    ST_RLO:  state <= sda_i ? ST_WAIT : ST_RHI;
                    default: state <= ST_WAIT;
                endcase
            end
        end else if (scl_fall_i) begin
            sda_oe_o <= drive_nxt;
        end
    end
endmodule

// File: rtl/vid_reg_bank.sv
// Module: holds the two VID codes and the power flag, applies committed
// words by command code, raises the change pulse and selects the output.
// Assumes commit_i is a single-cycle strobe with stable cmd/data.
module vid_reg_bank #(
    parameter int VID_W = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      commit_i,
    input  logic [vid_pkg::CMD_W-1:0] cmd_i,
    input  logic [VID_W-1:0]          lo_i,
    input  logic [VID_W-1:0]          hi_i,
    input  logic                      sel_i,
    output logic [VID_W-1:0]          vid0_o,
    output logic [VID_W-1:0]          vid1_o,
    output logic                      flag_o,
    output logic                      upd_o,
    output logic [VID_W-1:0]          vid_o
);
    import vid_pkg::*;

    logic vid_wr;
    logic pwr_wr;

    // Decode which register a committed word addresses.
    always_comb begin
        vid_wr = commit_i && (cmd_i == CMD_VID);
        pwr_wr = commit_i && (cmd_i == CMD_PWR);
    end

    // Update the VID codes and flag the change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vid0_o <= '1;
            vid1_o <= '1;
            upd_o  <= 1'b0;
        end else begin
            upd_o <= vid_wr && ((lo_i != vid0_o) || (hi_i != vid1_o));
            if (vid_wr) begin
                vid0_o <= lo_i;
                vid1_o <= hi_i;
            end
        end
    end

    // Update the power flag from the top data-low bit.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_o <= 1'b0;
        else if (pwr_wr) flag_o <= lo_i[VID_W-1];
    end

    // Route the selected code to the VID bus.
    assign vid_o = sel_i ? vid1_o : vid0_o;
endmodule

// File: rtl/smbus_vid_slave.sv
// Module: top of the SMBus VID slave; wires the line monitor, the word
// engine and the register bank.
// Assumes synchronized SCL/SDA inputs and an external open-drain SDA pad.
module smbus_vid_slave #(
    parameter logic [6:0] SLAVE_ADDR = 7'b1110001,
    parameter int         VID_W      = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic             vid_sel_i,
    output logic             sda_oe_o,
    output logic [VID_W-1:0] vid_o,
    output logic [VID_W-1:0] vid_reg0_o,
    output logic [VID_W-1:0] vid_reg1_o,
    output logic             pwr_on_o,
    output logic             upd_pulse_o
);
    import vid_pkg::*;

    logic             scl_rise;
    logic             scl_fall;
    logic             start_det;
    logic             stop_det;
    logic             commit;
    logic [CMD_W-1:0] cmd;
    logic [VID_W-1:0] lo_v;
    logic [VID_W-1:0] hi_v;

    smb_line_mon u_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    smb_word_fsm #(
        .SLAVE_ADDR (SLAVE_ADDR),
        .VID_W      (VID_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_i      (sda_i),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start_det),
        .stop_i     (stop_det),
        .rd_vid0_i  (vid_reg0_o),
        .rd_vid1_i  (vid_reg1_o),
        .rd_flag_i  (pwr_on_o),
        .sda_oe_o   (sda_oe_o),
        .commit_o   (commit),
        .cmd_o      (cmd),
        .lo_o       (lo_v),
        .hi_o       (hi_v)
    );

    vid_reg_bank #(
        .VID_W (VID_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit),
        .cmd_i    (cmd),
        .lo_i     (lo_v),
        .hi_i     (hi_v),
        .sel_i    (vid_sel_i),
        .vid0_o   (vid_reg0_o),
        .vid1_o   (vid_reg1_o),
        .flag_o   (pwr_on_o),
        .upd_o    (upd_pulse_o),
        .vid_o    (vid_o)
    );
endmodule

// File: rtl/smbus_vid_slave_chk.sv
// Module: assertion checker for the SMBus VID slave, bound to the top.
// Assumes the strobes of the line monitor are visible in the top module.
module smbus_vid_slave_chk #(
    parameter int VID_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_fall,
    input logic             start_det,
    input logic             stop_det,
    input logic             sda_oe,
    input logic [VID_W-1:0] vid0,
    input logic [VID_W-1:0] vid1,
    input logic             flag,
    input logic             upd
);
    // R10: SDA drive holds unless SCL fell or a bus condition occurred.
    a_r10_oe_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_fall && !start_det && !stop_det) |=> $stable(sda_oe));

    // R10: SDA is released after a STOP.
    a_r10_release_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R5: a pulse comes only with a real change of a VID register.
    a_r5_pulse_means_change: assert property (@(posedge clk) disable iff (!rst_n)
        upd |-> ((vid0 != $past(vid0)) || (vid1 != $past(vid1))));

    // R5: the pulse lasts a single cycle.
    a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> !upd);

    // R4: registers move only at a closing bus condition.
    a_r4_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_det && !stop_det) |=> ($stable(vid0) && $stable(vid1) && $stable(flag)));
endmodule

bind smbus_vid_slave smbus_vid_slave_chk #(.VID_W(VID_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe_o),
    .vid0      (vid_reg0_o),
    .vid1      (vid_reg1_o),
    .flag      (pwr_on_o),
    .upd       (upd_pulse_o)
);

// File: tb/smbus_vid_slave_tb.sv
// Bench: drives the bus as an SMBus host, walks a vector table of Write
// Word transfers, then runs directed tests for reset, addressing, abort,
// repeated start, read back and the power flag.
module smbus_vid_slave_tb;
    localparam int Q = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       sel = 1'b0;
    logic       sda_oe;
    logic       sda_line;
    logic [4:0] vid, r0, r1;
    logic       pwr, upd;
    int         runs = 0;
    int         fails = 0;
    int         pulses = 0;

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    smbus_vid_slave u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl),
        .sda_i       (sda_line),
        .vid_sel_i   (sel),
        .sda_oe_o    (sda_oe),
        .vid_o       (vid),
        .vid_reg0_o  (r0),
        .vid_reg1_o  (r1),
        .pwr_on_o    (pwr),
        .upd_pulse_o (upd)
    );

    always @(posedge clk) if (rst_n && upd) pulses <= pulses + 1;

    // vector: cmd, data-low, data-high, exp r0, exp r1, exp pulses, exp cmd ack
    localparam logic [35:0] VEC [8] = '{
        {8'h20, 8'hA8, 8'h38, 5'h15, 5'h07, 1'b1, 1'b1},
        {8'h3F, 8'h07, 8'hFF, 5'h00, 5'h1F, 1'b1, 1'b1},
        {8'h25, 8'h00, 8'hF8, 5'h00, 5'h1F, 1'b0, 1'b1},
        {8'h80, 8'h50, 8'h50, 5'h00, 5'h1F, 1'b0, 1'b0},
        {8'hE0, 8'h50, 8'h50, 5'h00, 5'h1F, 1'b0, 1'b0},
        {8'h00, 8'h10, 8'h10, 5'h00, 5'h1F, 1'b0, 1'b1},
        {8'h60, 8'h10, 8'h10, 5'h00, 5'h1F, 1'b0, 1'b1},
        {8'h21, 8'hF8, 8'h00, 5'h1F, 5'h00, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        runs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic qwait(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl = 1'b1; qwait(1);
        sda_m = 1'b0; qwait(1);
        scl = 1'b0; qwait(1);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; qwait(1);
        scl = 1'b1; qwait(1);
        sda_m = 1'b0; qwait(1);
        scl = 1'b0; qwait(1);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qwait(1);
        scl = 1'b1; qwait(1);
        sda_m = 1'b1; qwait(2);
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; qwait(1);
            scl = 1'b1; qwait(2);
            scl = 1'b0; qwait(1);
        end
        sda_m = 1'b1; qwait(1);
        scl = 1'b1; qwait(1);
        ack = ~sda_line;
        qwait(1);
        scl = 1'b0; qwait(1);
    endtask

    task automatic get_byte(input logic host_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            qwait(1);
            scl = 1'b1; qwait(1);
            b[i] = sda_line;
            qwait(1);
            scl = 1'b0;
        end
        qwait(1);
        sda_m = ~host_ack; qwait(1);
        scl = 1'b1; qwait(2);
        scl = 1'b0; qwait(1);
        sda_m = 1'b1;
    endtask

    task automatic write_word(input logic [7:0] cmd, input logic [7:0] lo,
                              input logic [7:0] hi, output logic cack);
        logic a;
        bus_start();
        put_byte(8'hE2, a);
        put_byte(cmd, cack);
        put_byte(lo, a);
        put_byte(hi, a);
        bus_stop();
    endtask

    task automatic read_word(input logic [7:0] cmd, output logic [7:0] lo, output logic [7:0] hi);
        logic a;
        bus_start();
        put_byte(8'hE2, a);
        put_byte(cmd, a);
        bus_rstart();
        put_byte(8'hE3, a);
        get_byte(1'b1, lo);
        get_byte(1'b0, hi);
        bus_stop();
    endtask

    initial begin : wd
        repeat (150000) @(posedge clk);
        runs++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end

    initial begin : main
        logic       ack;
        logic [7:0] blo, bhi;
        int         p0;

        repeat (5) @(negedge clk);
        chk("R2 reset r0", r0, 5'h1F);
        chk("R2 reset r1", r1, 5'h1F);
        chk("R2 reset flag", pwr, 1'b0);
        chk("R2 reset sda_oe", sda_oe, 1'b0);
        chk("R2 reset pulse", upd, 1'b0);
        rst_n = 1'b1;
        qwait(2);

        // Vector walk: R3/R4/R5/R9
        for (int k = 0; k < 8; k++) begin
            p0 = pulses;
            write_word(VEC[k][35:28], VEC[k][27:20], VEC[k][19:12], ack);
            chk("R3 command ack", ack, VEC[k][0]);
            chk("R4 reg0 after word", r0, VEC[k][11:7]);
            chk("R4 reg1 after word", r1, VEC[k][6:2]);
            chk("R5 pulse count", pulses - p0, VEC[k][1]);
            chk("R8 vid bus sel0", vid, VEC[k][11:7]);
        end

        // R8 select
        sel = 1'b1; #1;
        chk("R8 vid bus sel1", vid, 5'h00);
        sel = 1'b0; #1;
        chk("R8 vid bus sel0", vid, 5'h1F);

        // R1 wrong address
        p0 = pulses;
        bus_start();
        put_byte(8'hE4, ack);
        chk("R1 foreign address nack", ack, 1'b0);
        put_byte(8'h20, ack);
        put_byte(8'h00, ack);
        put_byte(8'h00, ack);
        bus_stop();
        chk("R1 foreign address r0", r0, 5'h1F);
        chk("R1 foreign address r1", r1, 5'h00);
        chk("R10 released after stop", sda_oe, 1'b0);

        // R6 abort after data-low
        bus_start();
        put_byte(8'hE2, ack);
        chk("R1 own address ack", ack, 1'b1);
        put_byte(8'h20, ack);
        put_byte(8'h00, ack);
        bus_stop();
        chk("R6 abort r0", r0, 5'h1F);
        chk("R6 abort r1", r1, 5'h00);
        chk("R6 abort pulse", pulses - p0, 0);

        // R4 commit on repeated start, R7 read back
        p0 = pulses;
        bus_start();
        put_byte(8'hE2, ack);
        put_byte(8'h20, ack);
        put_byte(8'h48, ack);
        put_byte(8'hB0, ack);
        bus_rstart();
        chk("R4 commit at repeated start r0", r0, 5'h09);
        chk("R4 commit at repeated start r1", r1, 5'h16);
        put_byte(8'hE3, ack);
        chk("R1 read address ack", ack, 1'b1);
        get_byte(1'b1, blo);
        get_byte(1'b0, bhi);
        bus_stop();
        chk("R7 read low byte", blo, 8'h48);
        chk("R7 read high byte", bhi, 8'hB0);
        chk("R5 pulse on rstart commit", pulses - p0, 1);
        chk("R10 released after read", sda_oe, 1'b0);

        // R9 power flag
        p0 = pulses;
        write_word(8'h40, 8'h80, 8'h00, ack);
        chk("R9 flag set", pwr, 1'b1);
        chk("R9 flag write leaves r0", r0, 5'h09);
        chk("R9 flag write leaves r1", r1, 5'h16);
        chk("R9 flag write no pulse", pulses - p0, 0);
        read_word(8'h40, blo, bhi);
        chk("R9 flag read low", blo, 8'h80);
        chk("R9 flag read high", bhi, 8'h00);
        write_word(8'h5F, 8'h7F, 8'hFF, ack);
        chk("R9 flag clear", pwr, 1'b0);
        read_word(8'h3C, blo, bhi);
        chk("R7 read low after flag", blo, 8'h48);
        chk("R7 read high after flag", bhi, 8'hB0);

        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end
endmodule